// File: doc/BRIEF.md
# Chained RGB Pixel Serial Receiver

This block is the input stage of one node in a string of RGB LED drivers that share one serial data line and one data clock. The controller first clocks in a run of zero bits that arms every node. Then it sends one 16-bit pixel frame per node, nearest node first. Each node keeps the first frame that follows the zero run. It forwards every later bit to the next node, together with a regenerated clock. After the last frame the controller sends extra clock pulses with the data line low. A node moves its captured colour into its active outputs on the first such pulse.

The data clock is assumed to be synchronous to the block clock `clk`. Each high phase and each low phase of the data clock lasts at least two `clk` cycles. A data clock rising edge is detected inside the block, and the data line is sampled in that same cycle. The forwarded data bit changes one `clk` cycle after the detected edge. The regenerated clock follows one cycle after that, so the next node always sees its data settled before its clock rises.

Top module: `pixrx_node`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, every register clears. After reset, `rgb_r`, `rgb_g`, `rgb_b`, `load`, `dout` and `dclk_out` all read 0, and the receiver is hunting for a start run.
- R2: A '1' bit arms capture only when at least 32 consecutive zero bits came before it. A '1' that follows fewer zeros is not captured, and the zero count starts again from zero.
- R3: The marker '1' is followed by 15 captured bits, most significant bit first. Bits 14..10 form red, bits 9..5 form green and bits 4..0 form blue.
- R4: The active colour outputs keep their previous value until the first zero bit that arrives at a frame boundary after the captured frame. In that same cycle the new colour appears and `load` is high for exactly one `clk` cycle.
- R5: `dout` is 0 for every bit received while hunting and while capturing the node's own frame. From the bit after the captured frame onward, `dout` carries the received bit. `dout` changes only in the cycle after a detected data clock rising edge.
- R6: `dclk_out` equals `dclk` delayed by two `clk` cycles. It therefore rises one cycle after `dout` takes the bit of that edge.
- R7: Zero bits beyond 32 keep the receiver hunting. Any longer zero run still arms capture.
- R8: After the captured frame, the receiver keeps 16-bit frame alignment. A '1' at a frame boundary starts a forwarded frame, and zeros inside forwarded grey fields never trigger a load. Forwarded frames leave `dout` bit-exact.
- R9: After a load, the receiver returns to hunting. A later transfer updates the colour again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Serial data from the upstream side |
| dclk | input | 1 | Serial data clock from the upstream side |
| dout | output | 1 | Serial data towards the next node |
| dclk_out | output | 1 | Regenerated data clock towards the next node |
| rgb_r | output | 5 | Active red grey level |
| rgb_g | output | 5 | Active green grey level |
| rgb_b | output | 5 | Active blue grey level |
| load | output | 1 | One-cycle pulse when a new colour becomes active |

## Verification
The node is driven with five kinds of stream:
- An exact 32-zero start run followed by a single frame and one trailing pulse. This separates correct capture and field order from a bit reversal.
- A stray '1' after only 20 zeros, then a proper transfer. This tells a restarting zero count from one that merely saturates.
- A 40-zero start run. This shows that surplus zeros are tolerated.
- A three-frame stream whose forwarded frames are mostly zeros, followed by three trailing pulses. This distinguishes frame-aligned load detection from loading on any zero, and checks the forwarded bits one by one.
- A second transfer. This confirms that the receiver re-arms and updates the active colour.

// File: rtl/pixrx_pkg.sv
// Shared types and defaults for the chained pixel receiver.
// Assumes nothing beyond the parameters of the top module.
package pixrx_pkg;
    // Receiver phases: hunting for the start run, grabbing own frame, passing downstream
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_GRAB = 2'd1,
        ST_PASS = 2'd2
    } rx_state_e;

    localparam int DEF_START_ZEROS = 32;
    localparam int DEF_GREY_W      = 5;
    localparam int DEF_NCH         = 3;
endpackage

// File: rtl/pixrx_edge.sv
// Data clock edge detector and clock regenerator.
// Assumes dclk is synchronous to clk, with each high and low phase at least two clk cycles.
// rise is high in the clk cycle where dclk is first seen high.
// dclk_out is dclk delayed by two clk cycles.
module pixrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk,
    output logic rise,
    output logic dclk_out
);
    logic dclk_q;
    logic dclk_q2;

    // Delay line for the data clock: one stage for edge detection, two for regeneration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk_q  <= 1'b0;
            dclk_q2 <= 1'b0;
        end else begin
            dclk_q  <= dclk;
            dclk_q2 <= dclk_q;
        end
    end

    // Rising edge seen in the current cycle
    assign rise     = dclk & ~dclk_q;
    assign dclk_out = dclk_q2;
endmodule

// File: rtl/pixrx_ctrl.sv
// Frame sequencer: counts the start run of zeros, grabs the node's own frame,
// then forwards bits downstream while keeping frame alignment.
// It raises load_req on the first zero seen at a frame boundary.
// Assumes bit_rise marks the cycle in which din holds a valid bit.
module pixrx_ctrl
    import pixrx_pkg::*;
#(
    parameter int START_ZEROS = DEF_START_ZEROS,
    parameter int GREY_W      = DEF_GREY_W,
    parameter int NCH         = DEF_NCH,
    parameter int WORD_W      = NCH * GREY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              din,
    output logic              dout,
    output logic              load_req,
    output logic [WORD_W-1:0] word
);
    localparam int FRAME_W = WORD_W + 1;
    localparam int ZC_W    = $clog2(START_ZEROS + 1);
    localparam int POS_W   = $clog2(FRAME_W);

    rx_state_e        st;
    logic [ZC_W-1:0]  zcnt;
    logic [POS_W-1:0] pos;
    logic             armed;

    // Start run complete
    assign armed = (zcnt == ZC_W'(START_ZEROS));

    // Trailing pulse detected at a frame boundary while passing
    assign load_req = bit_rise && (st == ST_PASS) && (pos == '0) && !din;

    // Sequencer, capture shifter and forwarded data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_HUNT;
            zcnt <= '0;
            pos  <= '0;
            word <= '0;
            dout <= 1'b0;
        end else if (bit_rise) begin
            dout <= (st == ST_PASS) ? din : 1'b0;
            case (st)
                ST_HUNT: begin
                    if (din) begin
                        zcnt <= '0;
                        if (armed) begin
                            st  <= ST_GRAB;
                            pos <= '0;
                        end
                    end else if (!armed) begin
                        zcnt <= zcnt + ZC_W'(1);
                    end
                end
                ST_GRAB: begin
                    word <= {word[WORD_W-2:0], din};
                    if (pos == POS_W'(WORD_W - 1)) begin
                        st  <= ST_PASS;
                        pos <= '0;
                    end else begin
                        pos <= pos + POS_W'(1);
                    end
                end
                ST_PASS: begin
                    if (pos == '0 && !din) begin
                        st   <= ST_HUNT;
                        zcnt <= ZC_W'(1);
                    end else if (pos == POS_W'(FRAME_W - 1)) begin
                        pos <= '0;
                    end else begin
                        pos <= pos + POS_W'(1);
                    end
                end
                default: st <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/pixrx_hold.sv
// Active colour register: takes the captured word on load_req,
// pulses load for one cycle and splits the word into channels.
// Channel 0 comes from the most significant field.
// Assumes load_req is a single-cycle request.
module pixrx_hold #(
    parameter int GREY_W = 5,
    parameter int NCH    = 3,
    parameter int WORD_W = NCH * GREY_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_req,
    input  logic [WORD_W-1:0]            word,
    output logic                         load,
    output logic [NCH-1:0][GREY_W-1:0]   grey
);
    logic [WORD_W-1:0] act;

    // Active word and load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= '0;
            load <= 1'b0;
        end else begin
            load <= load_req;
            if (load_req) act <= word;
        end
    end

    // Split into channels, first field first
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign grey[c] = act[WORD_W-1-c*GREY_W -: GREY_W];
    end
endmodule

// File: rtl/pixrx_node.sv
// Chained pixel receiver node: the top of the per-node serial input stage.
// It claims the first frame after a start run, forwards the rest
// with a regenerated clock, and presents red, green and blue grey levels.
// Assumes dclk is synchronous to clk and each dclk phase spans at least two clk cycles.
module pixrx_node
    import pixrx_pkg::*;
#(
    parameter int START_ZEROS = DEF_START_ZEROS,
    parameter int GREY_W      = DEF_GREY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              dclk,
    output logic              dout,
    output logic              dclk_out,
    output logic [GREY_W-1:0] rgb_r,
    output logic [GREY_W-1:0] rgb_g,
    output logic [GREY_W-1:0] rgb_b,
    output logic              load
);
    localparam int NCH    = 3;
    localparam int WORD_W = NCH * GREY_W;

    logic                       rise;
    logic                       load_req;
    logic [WORD_W-1:0]          word;
    logic [NCH-1:0][GREY_W-1:0] grey;

    pixrx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .dclk     (dclk),
        .rise     (rise),
        .dclk_out (dclk_out)
    );

    pixrx_ctrl #(
        .START_ZEROS (START_ZEROS),
        .GREY_W      (GREY_W),
        .NCH         (NCH),
        .WORD_W      (WORD_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (rise),
        .din      (din),
        .dout     (dout),
        .load_req (load_req),
        .word     (word)
    );

    pixrx_hold #(
        .GREY_W (GREY_W),
        .NCH    (NCH),
        .WORD_W (WORD_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .word     (word),
        .load     (load),
        .grey     (grey)
    );

    // Channel order: red first, then green, then blue
    assign rgb_r = grey[0];
    assign rgb_g = grey[1];
    assign rgb_b = grey[2];
endmodule

// File: rtl/pixrx_node_chk.sv
// Property checker for pixrx_node, attached with bind.
// It watches the ports only.
module pixrx_node_chk #(
    parameter int GREY_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dclk,
    input logic              dout,
    input logic              dclk_out,
    input logic [GREY_W-1:0] rgb_r,
    input logic [GREY_W-1:0] rgb_g,
    input logic [GREY_W-1:0] rgb_b,
    input logic              load
);
    // R4: load strobe lasts a single cycle
    assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R4: active colour only moves together with load
    assert_hold_until_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rgb_r, rgb_g, rgb_b}) |-> load);

    // R5: the trailing pulse that triggers a load is forwarded as zero
    assert_load_fwd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !dout);

    // R5: forwarded data moves only after a detected data clock rise
    assert_dout_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$stable(dout)) |-> ($past(dclk) && !$past(dclk, 2)));

    // R6: regenerated clock is the input clock two cycles later
    assert_clk_regen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (dclk_out == $past(dclk, 2)));
endmodule

bind pixrx_node pixrx_node_chk #(.GREY_W(GREY_W)) u_pixrx_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dclk     (dclk),
    .dout     (dout),
    .dclk_out (dclk_out),
    .rgb_r    (rgb_r),
    .rgb_g    (rgb_g),
    .rgb_b    (rgb_b),
    .load     (load)
);

// File: tb/test_pixrx_node.sv
// Scoreboard bench for pixrx_node.
// Driver tasks queue the expected forwarded bits and the expected colour loads.
// Monitors pop these queues and compare them at negedge clk.
module test_pixrx_node;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       dclk = 1'b0;
    logic       dout;
    logic       dclk_out;
    logic [4:0] rgb_r, rgb_g, rgb_b;
    logic       load;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic        fwd_q[$];
    logic [14:0] col_q[$];
    logic [14:0] cur_col = '0;
    logic        dclk_out_prev = 1'b0;
    logic        mon_on = 1'b0;

    always #2 clk = ~clk;

    pixrx_node i_pixrx_node (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .dclk     (dclk),
        .dout     (dout),
        .dclk_out (dclk_out),
        .rgb_r    (rgb_r),
        .rgb_g    (rgb_g),
        .rgb_b    (rgb_b),
        .load     (load)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one serial bit, plus the expected forwarded value and the R6 clock timing
    task automatic send_bit(input logic b, input logic fwd);
        din = b;
        fwd_q.push_back(fwd);
        repeat (2) @(negedge clk);
        dclk = 1'b1;
        @(negedge clk);
        chk("R6 dclk_out still low one cycle after dclk", {31'd0, dclk_out}, 32'd0);
        @(negedge clk);
        chk("R6 dclk_out high two cycles after dclk", {31'd0, dclk_out}, 32'd1);
        dclk = 1'b0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
    endtask

    // Frame: marker, then red, green, blue MSB first; own frames forward as zeros
    task automatic send_frame(input logic [14:0] col, input logic own);
        send_bit(1'b1, own ? 1'b0 : 1'b1);
        for (int i = 14; i >= 0; i--) send_bit(col[i], own ? 1'b0 : col[i]);
    endtask

    // Monitor: forwarded bits at each regenerated clock rise, loads against the colour queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (dclk_out && !dclk_out_prev) begin
                if (fwd_q.size() == 0) begin
                    chk("R5 unexpected forwarded bit", 32'd1, 32'd0);
                end else begin
                    chk("R5/R8 forwarded bit on dout", {31'd0, dout}, {31'd0, fwd_q.pop_front()});
                end
            end
            if (load) begin
                if (col_q.size() == 0) begin
                    chk("R4 unexpected load", 32'd1, 32'd0);
                end else begin
                    cur_col = col_q.pop_front();
                    chk("R3/R4 loaded colour", {17'd0, rgb_r, rgb_g, rgb_b}, {17'd0, cur_col});
                end
            end
        end
        dclk_out_prev = dclk_out;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset colour", {17'd0, rgb_r, rgb_g, rgb_b}, 32'd0);
        chk("R1 reset load", {31'd0, load}, 32'd0);
        chk("R1 reset dout", {31'd0, dout}, 32'd0);
        chk("R1 reset dclk_out", {31'd0, dclk_out}, 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // R3: exact start run, single frame, one trailing pulse
        send_zeros(32);
        send_frame(15'b10101_01010_11111, 1'b1);
        repeat (3) @(negedge clk);
        chk("R4 colour unchanged before trailing pulse", {17'd0, rgb_r, rgb_g, rgb_b}, 32'd0);
        col_q.push_back(15'b10101_01010_11111);
        send_bit(1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R3 red field", {27'd0, rgb_r}, 32'h15);
        chk("R3 green field", {27'd0, rgb_g}, 32'h0A);
        chk("R3 blue field", {27'd0, rgb_b}, 32'h1F);

        // R2: a '1' after too few zeros is ignored and the zero count restarts
        send_zeros(20);
        send_bit(1'b1, 1'b0);
        send_zeros(31);
        send_bit(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 short run does not capture", {17'd0, rgb_r, rgb_g, rgb_b}, {17'd0, cur_col});
        send_zeros(32);
        send_frame(15'b00011_11000_00110, 1'b1);
        col_q.push_back(15'b00011_11000_00110);
        send_bit(1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R2 capture after full run", {17'd0, rgb_r, rgb_g, rgb_b}, {17'd0, 15'b00011_11000_00110});

        // R7: longer start run still arms
        send_zeros(40);
        send_frame(15'b11111_00001_10000, 1'b1);
        col_q.push_back(15'b11111_00001_10000);
        send_bit(1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7 capture after 40 zeros", {17'd0, rgb_r, rgb_g, rgb_b}, {17'd0, 15'b11111_00001_10000});

        // R8: downstream frames full of zeros are forwarded, and the load waits for the boundary
        send_zeros(32);
        send_frame(15'b01100_10011_00101, 1'b1);
        send_frame(15'b00000_00000_00001, 1'b0);
        send_frame(15'b10000_00000_00000, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 no load inside forwarded frames", {17'd0, rgb_r, rgb_g, rgb_b}, {17'd0, 15'b11111_00001_10000});
        col_q.push_back(15'b01100_10011_00101);
        send_zeros(3);
        repeat (4) @(negedge clk);
        chk("R8 load after forwarded frames", {17'd0, rgb_r, rgb_g, rgb_b}, {17'd0, 15'b01100_10011_00101});

        // R9: new transfer re-arms and updates
        send_zeros(32);
        send_frame(15'b00001_00010_00100, 1'b1);
        col_q.push_back(15'b00001_00010_00100);
        send_bit(1'b0, 1'b0);
        repeat (6) @(negedge clk);
        chk("R9 second update", {17'd0, rgb_r, rgb_g, rgb_b}, {17'd0, 15'b00001_00010_00100});

        chk("R4 all expected loads seen", col_q.size(), 32'd0);
        chk("R8 all forwarded bits seen", fwd_q.size(), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule